// File: doc/BRIEF.md
# Opcode-Substituting Bank Register Unit

This unit sits on the bus between an 8-bit 6502-family CPU and memory. It extends the CPU's 64 KiB reach with four 8-bit bank registers, K0 to K3. K0 is the bank used for ordinary execution. On every opcode fetch the unit checks the fetched byte against a small set of opcodes the CPU leaves unused. For each match it gives the CPU a standard opcode in its place. It also schedules a side effect on the bank registers for one chosen bus cycle of that instruction. Every other byte passes through unchanged.

The side effects are of five kinds:
- a bank selection for the data cycles of one instruction, made either by a one-cycle prefix or by a combined load/store opcode;
- an exchange of K0 and K3 at the end of a far jump, call, return or initialisation exchange;
- injection of a bank register into a stack push;
- capture of a pulled stack byte into a bank register;
- capture of an immediate operand into a bank register.

The unit counts bus cycles from the opcode fetch. It places each side effect on the cycle where the standard timing of the substituted opcode puts the matching bus access. One clock is one bus cycle.

Top module: `opsub_bank_unit`

## Requirements
- R1: While reset is asserted, all four bank registers are zero and no prefix or pending side effect survives. After reset `bank_out` is 0x00.
- R2: On cycles with `cpu_sync` low, `cpu_rdata` equals `mem_rdata`. On a fetch of any opcode not listed in R3, `cpu_rdata` equals the fetched byte. `mem_wdata` equals `cpu_wdata` except on the injection cycle of R5.
- R3: On a fetch the CPU receives the following replacements:
  - 0x83, 0xC3 and 0x43 become 0x03.
  - 0xF3, 0xE3 and 0xD3 become 0xA1, 0xB1 and 0xAD.
  - 0xB3, 0xA3 and 0x93 become 0x81, 0x91 and 0x8D.
  - 0x13, 0x23, 0xEB and 0xFB become 0x4C, 0x20, 0x60 and 0x40.
  - 0x4B, 0x6B, 0x7B and 0x5B become 0x08.
  - 0x63, 0x73 and 0x53 become 0x7A.
  - 0x42, 0xC2, 0xE2 and 0x5C pass unchanged.
- R4: After a fetch of 0x42, 0xC2 or 0xE2, the byte read on cycle 1 (the fetch is cycle 0) is written into K1, K2 or K3 respectively.
- R5: After a fetch of 0x4B, 0x6B, 0x7B or 0x5B, a write on cycle 2 to page 0x01 (address bits 15:8 equal 0x01) drives `mem_wdata` with K0, K1, K2 or K3 respectively.
- R6: After a fetch of 0x63, 0x73 or 0x53, a read on cycle 3 from page 0x01 is passed to the CPU unchanged and also written into K1, K2 or K3 respectively.
- R7: A prefix 0x83, 0xC3 or 0x43 makes `bank_out` show K1, K2 or K3 on the non-fetch cycles of the next instruction only. From the fetch after that instruction, `bank_out` shows K0 again.
- R8: Opcodes 0xF3, 0xE3 and 0xD3 make `bank_out` show K2, and 0xB3, 0xA3 and 0x93 make it show K1, on the non-fetch cycles of that same instruction.
- R9: K0 and K3 are exchanged at the end of the last cycle of a far control-flow instruction. That is cycle 2 for 0x13, and cycle 5 for 0x23, 0xEB and 0xFB. The next fetch therefore already uses the new K0.
- R10: Opcode 0x5C exchanges K0 and K3 at the end of its cycle 7. The exchange is not visible on any earlier cycle of that instruction.
- R11: If the next opcode fetch arrives before the scheduled cycle of a side effect, that side effect is dropped and no bank register changes.
- R12: During an opcode fetch `bank_out` always equals K0, whatever prefix or combined opcode is in force.
- R13: A push's cycle-2 write outside page 0x01 passes `cpu_wdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bus cycle per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Address driven by the CPU |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_sync | input | 1 | High during an opcode fetch cycle |
| mem_rdata | input | 8 | Byte returned by memory |
| cpu_rdata | output | 8 | Byte handed to the CPU, possibly substituted |
| cpu_wdata | input | 8 | Byte written by the CPU |
| mem_wdata | output | 8 | Byte sent to memory, possibly injected |
| bank_out | output | 8 | Bank bits extending the current access |

## Verification
The bank registers are hidden, so the hardest part is watching them change. The pull capture and the K0/K3 exchange have nothing on the bus that shows the new value at once. The bench reads every register back through the block's own push path: it issues the four push opcodes and compares each injected byte with a model it keeps from the loads, pulls and exchanges it has issued. Dropped side effects are reached by asserting the next opcode fetch one or more cycles early. The register readback then confirms that nothing moved.

// File: rtl/opsub_pkg.sv
package opsub_pkg;
  localparam int DATA_W    = 8;
  localparam int NUM_BANKS = 4;
  localparam int IDX_W     = $clog2(NUM_BANKS);
  localparam int CYC_W     = 3;

  typedef enum logic [2:0] {FX_NONE, FX_LOADI, FX_PUSH, FX_PULL, FX_SWAP} fx_kind_t;
  typedef enum logic [1:0] {BS_NONE, BS_PREFIX, BS_INLINE} bsel_kind_t;

  typedef struct packed {
    logic [DATA_W-1:0] cpu_op;
    fx_kind_t          fx;
    bsel_kind_t        bsel;
    logic [IDX_W-1:0]  idx;
    logic [CYC_W-1:0]  evt_cyc;
  } dec_t;

  function automatic dec_t mk_dec(logic [DATA_W-1:0] op, fx_kind_t fx, bsel_kind_t bs,
                                  logic [IDX_W-1:0] idx, logic [CYC_W-1:0] evt);
    dec_t d;
    d.cpu_op  = op;
    d.fx      = fx;
    d.bsel    = bs;
    d.idx     = idx;
    d.evt_cyc = evt;
    return d;
  endfunction

  // Recognise an extended opcode: replacement byte, side effect, target, event cycle
  function automatic dec_t decode_op(logic [DATA_W-1:0] op);
    case (op)
      8'h83: return mk_dec(8'h03, FX_NONE, BS_PREFIX, 2'd1, 3'd0);
      8'hC3: return mk_dec(8'h03, FX_NONE, BS_PREFIX, 2'd2, 3'd0);
      8'h43: return mk_dec(8'h03, FX_NONE, BS_PREFIX, 2'd3, 3'd0);
      8'hF3: return mk_dec(8'hA1, FX_NONE, BS_INLINE, 2'd2, 3'd0);
      8'hE3: return mk_dec(8'hB1, FX_NONE, BS_INLINE, 2'd2, 3'd0);
      8'hD3: return mk_dec(8'hAD, FX_NONE, BS_INLINE, 2'd2, 3'd0);
      8'hB3: return mk_dec(8'h81, FX_NONE, BS_INLINE, 2'd1, 3'd0);
      8'hA3: return mk_dec(8'h91, FX_NONE, BS_INLINE, 2'd1, 3'd0);
      8'h93: return mk_dec(8'h8D, FX_NONE, BS_INLINE, 2'd1, 3'd0);
      8'h13: return mk_dec(8'h4C, FX_SWAP, BS_NONE, 2'd3, 3'd2);
      8'h23: return mk_dec(8'h20, FX_SWAP, BS_NONE, 2'd3, 3'd5);
      8'hEB: return mk_dec(8'h60, FX_SWAP, BS_NONE, 2'd3, 3'd5);
      8'hFB: return mk_dec(8'h40, FX_SWAP, BS_NONE, 2'd3, 3'd5);
      8'h5C: return mk_dec(8'h5C, FX_SWAP, BS_NONE, 2'd3, 3'd7);
      8'h4B: return mk_dec(8'h08, FX_PUSH, BS_NONE, 2'd0, 3'd2);
      8'h6B: return mk_dec(8'h08, FX_PUSH, BS_NONE, 2'd1, 3'd2);
      8'h7B: return mk_dec(8'h08, FX_PUSH, BS_NONE, 2'd2, 3'd2);
      8'h5B: return mk_dec(8'h08, FX_PUSH, BS_NONE, 2'd3, 3'd2);
      8'h63: return mk_dec(8'h7A, FX_PULL, BS_NONE, 2'd1, 3'd3);
      8'h73: return mk_dec(8'h7A, FX_PULL, BS_NONE, 2'd2, 3'd3);
      8'h53: return mk_dec(8'h7A, FX_PULL, BS_NONE, 2'd3, 3'd3);
      8'h42: return mk_dec(8'h42, FX_LOADI, BS_NONE, 2'd1, 3'd1);
      8'hC2: return mk_dec(8'hC2, FX_LOADI, BS_NONE, 2'd2, 3'd1);
      8'hE2: return mk_dec(8'hE2, FX_LOADI, BS_NONE, 2'd3, 3'd1);
      default: return mk_dec(op, FX_NONE, BS_NONE, 2'd0, 3'd0);
    endcase
  endfunction

  // Pick one bank register out of the flattened file
  function automatic logic [DATA_W-1:0] pick_bank(logic [NUM_BANKS*DATA_W-1:0] flat,
                                                  logic [IDX_W-1:0] idx);
    return flat[idx*DATA_W +: DATA_W];
  endfunction
endpackage

// File: rtl/opsub_decoder.sv
module opsub_decoder
  import opsub_pkg::*;
(
  input  logic [DATA_W-1:0] fetch_byte,
  output dec_t              dec
);
  always_comb dec = decode_op(fetch_byte);
endmodule

// File: rtl/opsub_sequencer.sv
module opsub_sequencer
  import opsub_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic             rw,
  input  logic             in_stack,
  input  fx_kind_t         new_fx,
  input  bsel_kind_t       new_bsel,
  input  logic [IDX_W-1:0] new_idx,
  input  logic [CYC_W-1:0] new_evt,
  output logic             act_valid,
  output logic [IDX_W-1:0] act_idx,
  output logic [IDX_W-1:0] fx_idx,
  output logic             push_fire,
  output logic             capture_fire,
  output logic             swap_fire
);
  localparam logic [CYC_W-1:0] CYC_MAX = {CYC_W{1'b1}};

  fx_kind_t         fx_q;
  logic [CYC_W-1:0] evt_q;
  logic [CYC_W-1:0] cyc_q;
  logic             pend_v;
  logic [IDX_W-1:0] pend_idx;
  logic             ev_hit;

  // The scheduled cycle is reached only if no new fetch has started
  assign ev_hit       = !sync && (fx_q != FX_NONE) && (cyc_q == evt_q);
  assign push_fire    = ev_hit && (fx_q == FX_PUSH) && !rw && in_stack;
  assign capture_fire = ev_hit && rw &&
                        ((fx_q == FX_LOADI) || ((fx_q == FX_PULL) && in_stack));
  assign swap_fire    = ev_hit && (fx_q == FX_SWAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fx_q      <= FX_NONE;
      evt_q     <= '0;
      fx_idx    <= '0;
      cyc_q     <= '0;
      pend_v    <= 1'b0;
      pend_idx  <= '0;
      act_valid <= 1'b0;
      act_idx   <= '0;
    end else if (sync) begin
      fx_q   <= new_fx;
      evt_q  <= new_evt;
      fx_idx <= new_idx;
      cyc_q  <= CYC_W'(1);
      case (new_bsel)
        BS_PREFIX: begin
          pend_v    <= 1'b1;
          pend_idx  <= new_idx;
          act_valid <= 1'b0;
        end
        BS_INLINE: begin
          pend_v    <= 1'b0;
          act_valid <= 1'b1;
          act_idx   <= new_idx;
        end
        default: begin
          pend_v    <= 1'b0;
          act_valid <= pend_v;
          act_idx   <= pend_idx;
        end
      endcase
    end else begin
      if (ev_hit) fx_q <= FX_NONE;
      if (cyc_q != CYC_MAX) cyc_q <= cyc_q + CYC_W'(1);
    end
  end
endmodule

// File: rtl/opsub_bank_file.sv
module opsub_bank_file
  import opsub_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          swap_en,
  output logic [NUM_BANKS*DATA_W-1:0]   bank_flat
);
  localparam int SWAP_HI = NUM_BANKS - 1;

  logic [DATA_W-1:0] bank_q [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[g] <= '0;
      end else if (swap_en && (g == 0)) begin
        bank_q[g] <= bank_q[SWAP_HI];
      end else if (swap_en && (g == SWAP_HI)) begin
        bank_q[g] <= bank_q[0];
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        bank_q[g] <= wr_data;
      end
    end
    assign bank_flat[g*DATA_W +: DATA_W] = bank_q[g];
  end
endmodule

// File: rtl/opsub_bank_unit.sv
module opsub_bank_unit
  import opsub_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [7:0]  STACK_PAGE = 8'h01
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic              cpu_sync,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] bank_out
);
  localparam logic [ADDR_W-1:0] PAGE_MASK  = ~ADDR_W'(255);
  localparam logic [ADDR_W-1:0] STACK_BASE = ADDR_W'(STACK_PAGE) << 8;

  function automatic logic is_stack(logic [ADDR_W-1:0] a);
    return (a & PAGE_MASK) == STACK_BASE;
  endfunction

  dec_t                        dec;
  logic                        in_stack;
  logic                        act_valid;
  logic [IDX_W-1:0]            act_idx;
  logic [IDX_W-1:0]            fx_idx;
  logic                        push_fire;
  logic                        capture_fire;
  logic                        swap_fire;
  logic [NUM_BANKS*DATA_W-1:0] bank_flat;

  assign in_stack = is_stack(cpu_addr);

  opsub_decoder u_dec (
    .fetch_byte (mem_rdata),
    .dec        (dec)
  );

  opsub_sequencer u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync         (cpu_sync),
    .rw           (cpu_rw),
    .in_stack     (in_stack),
    .new_fx       (dec.fx),
    .new_bsel     (dec.bsel),
    .new_idx      (dec.idx),
    .new_evt      (dec.evt_cyc),
    .act_valid    (act_valid),
    .act_idx      (act_idx),
    .fx_idx       (fx_idx),
    .push_fire    (push_fire),
    .capture_fire (capture_fire),
    .swap_fire    (swap_fire)
  );

  opsub_bank_file u_banks (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (capture_fire),
    .wr_idx    (fx_idx),
    .wr_data   (mem_rdata),
    .swap_en   (swap_fire),
    .bank_flat (bank_flat)
  );

  assign cpu_rdata = cpu_sync ? dec.cpu_op : mem_rdata;
  assign mem_wdata = push_fire ? pick_bank(bank_flat, fx_idx) : cpu_wdata;
  assign bank_out  = (!cpu_sync && act_valid) ? pick_bank(bank_flat, act_idx)
                                              : pick_bank(bank_flat, '0);
endmodule

// File: rtl/opsub_bank_checker.sv
module opsub_bank_checker
  import opsub_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cpu_sync,
  input logic [DATA_W-1:0]           mem_rdata,
  input logic [DATA_W-1:0]           cpu_rdata,
  input logic [DATA_W-1:0]           cpu_wdata,
  input logic [DATA_W-1:0]           mem_wdata,
  input logic [DATA_W-1:0]           bank_out,
  input logic [NUM_BANKS*DATA_W-1:0] bank_flat,
  input logic [IDX_W-1:0]            fx_idx,
  input logic                        push_fire,
  input logic                        capture_fire,
  input logic                        swap_fire
);
  localparam int HI = NUM_BANKS - 1;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> bank_flat == '0);

  assert_data_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_sync |-> cpu_rdata == mem_rdata);

  assert_write_passthru_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !push_fire |-> mem_wdata == cpu_wdata);

  assert_capture_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    capture_fire |=> pick_bank(bank_flat, $past(fx_idx)) == $past(mem_rdata));

  assert_swap_exchange_R9: assert property (@(posedge clk) disable iff (!rst_n)
    swap_fire |=> (pick_bank(bank_flat, '0) == $past(pick_bank(bank_flat, HI[IDX_W-1:0])))
               && (pick_bank(bank_flat, HI[IDX_W-1:0]) == $past(pick_bank(bank_flat, '0))));

  assert_fetch_uses_k0_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_sync |-> bank_out == pick_bank(bank_flat, '0));

  assert_one_effect_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_fire, capture_fire, swap_fire}));

  assert_no_effect_on_fetch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_sync |-> !(push_fire || capture_fire || swap_fire));
endmodule

bind opsub_bank_unit opsub_bank_checker u_opsub_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_sync     (cpu_sync),
  .mem_rdata    (mem_rdata),
  .cpu_rdata    (cpu_rdata),
  .cpu_wdata    (cpu_wdata),
  .mem_wdata    (mem_wdata),
  .bank_out     (bank_out),
  .bank_flat    (bank_flat),
  .fx_idx       (fx_idx),
  .push_fire    (push_fire),
  .capture_fire (capture_fire),
  .swap_fire    (swap_fire)
);

// File: tb/opsub_bank_unit_bench.sv
module opsub_bank_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rw = 1'b1;
  logic        cpu_sync = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic [7:0]  mem_wdata;
  logic [7:0]  bank_out;

  int ntests = 0;
  int nfail  = 0;
  logic [7:0] km [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  opsub_bank_unit u_opsub_bank_unit (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .cpu_sync(cpu_sync), .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata),
    .cpu_wdata(cpu_wdata), .mem_wdata(mem_wdata), .bank_out(bank_out)
  );

  function automatic logic [7:0] exp_sub(logic [7:0] op);
    case (op)
      8'h83, 8'hC3, 8'h43: return 8'h03;
      8'hF3: return 8'hA1;  8'hE3: return 8'hB1;  8'hD3: return 8'hAD;
      8'hB3: return 8'h81;  8'hA3: return 8'h91;  8'h93: return 8'h8D;
      8'h13: return 8'h4C;  8'h23: return 8'h20;
      8'hEB: return 8'h60;  8'hFB: return 8'h40;
      8'h4B, 8'h6B, 8'h7B, 8'h5B: return 8'h08;
      8'h63, 8'h73, 8'h53: return 8'h7A;
      default: return op;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus cycle: drive after the falling edge, let logic settle, caller samples
  task automatic bus(input logic s, input logic rw, input logic [15:0] a,
                     input logic [7:0] rd, input logic [7:0] wd);
    @(negedge clk);
    cpu_sync = s; cpu_rw = rw; cpu_addr = a; mem_rdata = rd; cpu_wdata = wd;
    #1;
  endtask

  task automatic fetch(input logic [7:0] op);
    bus(1'b1, 1'b1, 16'h0400, op, 8'h00);
  endtask

  task automatic load_bank(input int n, input logic [7:0] v);
    logic [7:0] ops [4] = '{8'hEA, 8'h42, 8'hC2, 8'hE2};
    fetch(ops[n]);
    bus(1'b0, 1'b1, 16'h0401, v, 8'h00);
    km[n] = v;
  endtask

  // Bring every bank register out through the push path (R5)
  task automatic read_banks(input string req);
    logic [7:0] ops [4] = '{8'h4B, 8'h6B, 8'h7B, 8'h5B};
    for (int i = 0; i < 4; i++) begin
      fetch(ops[i]);
      bus(1'b0, 1'b1, 16'h0401, 8'h00, 8'h00);
      bus(1'b0, 1'b0, 16'h01F0, 8'h00, 8'hEE);
      chk(req, mem_wdata, km[i]);
    end
  endtask

  task automatic swap_model();
    logic [7:0] t;
    t = km[0]; km[0] = km[3]; km[3] = t;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) km[i] = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", bank_out, 8'h00);
    rst_n = 1'b1;
    read_banks("R1");

    // R3/R2: every opcode value on a fetch cycle
    for (int op = 0; op < 256; op++) begin
      fetch(8'(op));
      chk("R3", cpu_rdata, exp_sub(8'(op)));
      chk("R12", bank_out, km[0]);
    end

    // R2: every byte on non-fetch reads passes unchanged
    fetch(8'hEA);
    for (int v = 0; v < 256; v++) begin
      bus(1'b0, 1'b1, 16'h2000, 8'(v), 8'(255 - v));
      chk("R2", cpu_rdata, 8'(v));
      chk("R2", mem_wdata, 8'(255 - v));
    end
    read_banks("R11");

    // R4: immediate loads
    load_bank(1, 8'h15);
    load_bank(2, 8'h26);
    load_bank(3, 8'h37);
    read_banks("R4");

    // R6: pull into K2, byte still goes to the CPU
    fetch(8'h73);
    chk("R6", cpu_rdata, 8'h7A);
    bus(1'b0, 1'b1, 16'h0401, 8'h11, 8'h00);
    bus(1'b0, 1'b1, 16'h01FE, 8'h22, 8'h00);
    bus(1'b0, 1'b1, 16'h01FF, 8'hC4, 8'h00);
    chk("R6", cpu_rdata, 8'hC4);
    km[2] = 8'hC4;
    read_banks("R6");

    // R13: push write outside the stack page is untouched
    fetch(8'h6B);
    bus(1'b0, 1'b1, 16'h0401, 8'h00, 8'h00);
    bus(1'b0, 1'b0, 16'h2000, 8'h00, 8'h77);
    chk("R13", mem_wdata, 8'h77);

    // R7: prefix K2 applies to the next instruction only
    fetch(8'hC3);
    chk("R7", bank_out, km[0]);
    bus(1'b0, 1'b1, 16'h0401, 8'h00, 8'h00);
    chk("R7", bank_out, km[0]);
    fetch(8'hAD);
    chk("R12", bank_out, km[0]);
    for (int c = 1; c < 4; c++) begin
      bus(1'b0, 1'b1, 16'h3000, 8'h00, 8'h00);
      chk("R7", bank_out, km[2]);
    end
    fetch(8'hEA);
    chk("R7", bank_out, km[0]);
    bus(1'b0, 1'b1, 16'h0401, 8'h00, 8'h00);
    chk("R7", bank_out, km[0]);

    // R8: combined opcodes
    fetch(8'hD3);
    for (int c = 1; c < 4; c++) begin
      bus(1'b0, 1'b1, 16'h3000, 8'h00, 8'h00);
      chk("R8", bank_out, km[2]);
    end
    fetch(8'h93);
    for (int c = 1; c < 4; c++) begin
      bus(1'b0, 1'b0, 16'h3000, 8'h00, 8'h00);
      chk("R8", bank_out, km[1]);
    end

    // R9: far control flow swaps K0 and K3 at the last cycle
    load_bank(3, 8'h5A);
    fetch(8'h13);
    bus(1'b0, 1'b1, 16'h0401, 8'h00, 8'h00);
    bus(1'b0, 1'b1, 16'h0402, 8'h00, 8'h00);
    chk("R9", bank_out, km[0]);
    swap_model();
    fetch(8'hEA);
    chk("R9", bank_out, km[0]);
    begin
      logic [7:0] fops [3] = '{8'h23, 8'hEB, 8'hFB};
      for (int k = 0; k < 3; k++) begin
        load_bank(3, 8'(8'h60 + k));
        fetch(fops[k]);
        for (int c = 1; c < 6; c++) begin
          bus(1'b0, 1'b1, 16'h01F8, 8'h00, 8'h00);
          chk("R9", bank_out, km[0]);
        end
        swap_model();
        fetch(8'hEA);
        chk("R9", bank_out, km[0]);
      end
    end
    read_banks("R9");

    // R10: 0x5C exchange after eight cycles
    load_bank(3, 8'hA5);
    fetch(8'h5C);
    chk("R10", cpu_rdata, 8'h5C);
    for (int c = 1; c < 8; c++) begin
      bus(1'b0, 1'b1, 16'h0401, 8'h00, 8'h00);
      chk("R10", bank_out, km[0]);
    end
    swap_model();
    fetch(8'hEA);
    chk("R10", bank_out, km[0]);
    read_banks("R10");

    // R11: early fetch drops pending side effects
    fetch(8'h42);
    fetch(8'hEA);
    fetch(8'h13);
    bus(1'b0, 1'b1, 16'h0401, 8'h00, 8'h00);
    fetch(8'hEA);
    chk("R11", bank_out, km[0]);
    fetch(8'h63);
    bus(1'b0, 1'b1, 16'h0401, 8'h99, 8'h00);
    bus(1'b0, 1'b1, 16'h01FE, 8'h99, 8'h00);
    fetch(8'hEA);
    read_banks("R11");

    // R1: reset again clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < 4; i++) km[i] = 8'h00;
    chk("R1", bank_out, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    read_banks("R1");

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule